// File: doc/BRIEF.md
# Fast Overcurrent Sinc Detector

This block takes a 1-bit delta-sigma bitstream, one bit per modulator clock, and produces a coarse signed reading a few data periods after the input moves. It runs beside the precision decimation path on the same bitstream and gives up resolution for speed. Two second-order responses are selectable. The plain second-order sinc is a cascade of two boxcar sums of OSR bits. The fast variant adds that result to a copy of itself delayed by two decimated samples, which doubles the gain and shapes the step response.

Each reading is compared against a programmable signed window. The first reading outside the window raises a latched trip flag, which power-stage protection logic can use. The comparison stays off for a fixed number of readings after reset, so the partial windows that follow reset cannot trip the flag. The flag is cleared only by a clear pulse, and only while the latest compared reading is back inside the window. The OSR select and the filter mode are assumed to be held steady outside reset.

Top module: `ocd_detector`

## Requirements
- R1: Reset is synchronous and active-low. While it is applied, `data_out` is 0, `data_valid` is 0 and `trip` is 0, even if the flag was set before.
- R2: `osr_sel` value s selects OSR = 8·2^s (8, 16, 32, 64). Once running, `data_valid` is a single-cycle pulse exactly once every OSR clocks.
- R3: With `fast_en`=0, each reading is the double boxcar sum of the stream minus OSR²/2. A settled stream that repeats a 4-bit pattern with p ones reads OSR²·(p−2)/4.
- R4: With `fast_en`=1, each reading is the double boxcar sum plus the same sum from two readings earlier, minus OSR². A settled stream that repeats a 4-bit pattern with p ones reads OSR²·(p−2)/2.
- R5: `data_out` is 14-bit two's complement, and every reading lies within ±OSR²/2 (second-order mode) or ±OSR² (fast mode).
- R6: After reset, the first 3 readings (second-order mode) or the first 5 readings (fast mode) are never compared and cannot set `trip`. The first reading is negative because its window is partial.
- R7: A compared reading strictly above `thr_hi` or strictly below `thr_lo` (both signed) sets `trip` on the clock after its `data_valid` pulse. A reading equal to a threshold does not set it.
- R8: Once set, `trip` stays high while no clear is requested, including after readings return inside the window.
- R9: A `trip_clr` pulse lowers `trip` on the next clock when the latest compared reading was inside the window. The pulse is ignored when that reading was outside.
- R10: After a step from density 1/2 to density 3/4, with the window set at half the step height, `trip` rises within 5 data periods (5·OSR clocks) of the first new bit, in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator clock; one stream bit per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_in | input | 1 | Modulator bitstream |
| osr_sel | input | 2 | Decimation select, OSR = 8·2^osr_sel |
| fast_en | input | 1 | 1 selects the fast response, 0 the plain second-order sinc |
| thr_hi | input | 14 | Signed upper trip threshold |
| thr_lo | input | 14 | Signed lower trip threshold |
| trip_clr | input | 1 | Request to clear the latched trip flag |
| data_out | output | 14 | Signed filtered reading |
| data_valid | output | 1 | One-cycle strobe marking a new reading |
| trip | output | 1 | Latched overcurrent flag |

## Verification
The bench goes after the start-up window. There, a design that compared too early would trip on the strongly negative first reading of an alternating stream. It checks the exact equality of a reading with the threshold, where an off-by-one comparator trips when it should not. The clear path is driven while the reading is still outside the window and again after it returns inside. A flag that cleared unconditionally, or one that dropped by itself, shows up there. Settled readings for several densities, across all four OSR values and both modes, expose a wrong offset, a wrong delay tap or a truncated integrator. A step test bounds the trip latency in data periods.

// File: rtl/ocd_pkg.sv
// Shared constants and types for the fast overcurrent sinc detector.
// Assumes power-of-two OSR values between 2^OCD_OSR_LOG2_MIN and 2^OCD_OSR_LOG2_MAX.
package ocd_pkg;
    localparam int OCD_OSR_LOG2_MIN = 3;
    localparam int OCD_OSR_LOG2_MAX = 6;
    localparam int OCD_DATA_W       = 2 * OCD_OSR_LOG2_MAX + 2;
    localparam int OCD_LAG          = 2;
    localparam int OCD_SETTLE_SINC2 = 3;
    localparam int OCD_SETTLE_FAST  = 5;

    typedef enum logic {
        FILT_SINC2 = 1'b0,
        FILT_FAST  = 1'b1
    } filt_mode_e;
endpackage

// File: rtl/ocd_cic2.sv
// Second-order cascaded integrator-comb decimator.
// Integrates the 1-bit stream at the modulator rate and differences once per
// OSR clocks. Assumes osr_sel is steady outside reset. Modular arithmetic is
// exact because ACC_W covers OSR_max^2 plus a sign bit.
module ocd_cic2 #(
    parameter int OSR_LOG2_MIN = 3,
    parameter int OSR_LOG2_MAX = 6,
    parameter int SEL_W        = 2,
    parameter int ACC_W        = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_in,
    input  logic [SEL_W-1:0] osr_sel,
    output logic [ACC_W-1:0] comb_out,
    output logic             comb_stb
);
    localparam int ORDER = 2;
    localparam int CNT_W = OSR_LOG2_MAX;

    logic [CNT_W-1:0] phase_q;
    logic [CNT_W-1:0] phase_last;
    logic             dec_hit;
    logic [ACC_W-1:0] integ_w [ORDER];
    logic [ACC_W-1:0] comb_w  [ORDER+1];

    assign phase_last = CNT_W'((1 << (OSR_LOG2_MIN + int'(osr_sel))) - 1);
    assign dec_hit    = (phase_q == phase_last);

    // Decimation phase counter, wraps every OSR clocks.
    always_ff @(posedge clk) begin
        if (!rst_n)       phase_q <= '0;
        else if (dec_hit) phase_q <= '0;
        else              phase_q <= phase_q + 1'b1;
    end

    for (genvar g = 0; g < ORDER; g++) begin : g_integ
        logic [ACC_W-1:0] acc_q;
        if (g == 0) begin : g_first
            // First integrator accumulates raw stream bits.
            always_ff @(posedge clk) begin
                if (!rst_n) acc_q <= '0;
                else        acc_q <= acc_q + ACC_W'(bit_in);
            end
        end else begin : g_next
            // Later integrators accumulate the previous stage.
            always_ff @(posedge clk) begin
                if (!rst_n) acc_q <= '0;
                else        acc_q <= acc_q + integ_w[g-1];
            end
        end
        assign integ_w[g] = acc_q;
    end

    assign comb_w[0] = integ_w[ORDER-1];

    for (genvar g = 0; g < ORDER; g++) begin : g_comb
        logic [ACC_W-1:0] dly_q;
        assign comb_w[g+1] = comb_w[g] - dly_q;
        // Comb delay element, advanced only at the decimated rate.
        always_ff @(posedge clk) begin
            if (!rst_n)       dly_q <= '0;
            else if (dec_hit) dly_q <= comb_w[g];
        end
    end

    // Register the decimated comb result and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            comb_out <= '0;
            comb_stb <= 1'b0;
        end else begin
            comb_stb <= dec_hit;
            if (dec_hit) comb_out <= comb_w[ORDER];
        end
    end
endmodule

// File: rtl/ocd_fast_term.sv
// Optional two-sample echo term and mid-scale offset removal.
// In fast mode it adds the comb result from two readings back, and it removes
// half of the full-scale sum so that the reading is signed around zero.
// Assumes one comb strobe per OSR clocks.
module ocd_fast_term #(
    parameter int OSR_LOG2_MIN = 3,
    parameter int SEL_W        = 2,
    parameter int DATA_W       = 14,
    parameter int LAG          = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fast_en,
    input  logic [SEL_W-1:0]         osr_sel,
    input  logic [DATA_W-1:0]        comb_in,
    input  logic                     comb_stb,
    output logic signed [DATA_W-1:0] data_out,
    output logic                     data_valid
);
    localparam int SUM_W = DATA_W + 1;

    logic [DATA_W-1:0] lag_q [LAG];
    logic [SUM_W-1:0]  half_scale;
    logic [SUM_W-1:0]  tail;
    logic [SUM_W-1:0]  total;

    // Offset, echo term and signed sum for the current comb result.
    always_comb begin
        half_scale = SUM_W'(1) << (2 * (OSR_LOG2_MIN + int'(osr_sel)) - (fast_en ? 0 : 1));
        tail       = fast_en ? {1'b0, lag_q[LAG-1]} : '0;
        total      = {1'b0, comb_in} + tail - half_scale;
    end

    // History of earlier comb results, shifted once per reading.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < LAG; k++) lag_q[k] <= '0;
        end else if (comb_stb) begin
            lag_q[0] <= comb_in;
            for (int k = 1; k < LAG; k++) lag_q[k] <= lag_q[k-1];
        end
    end

    // Output register for the reading and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_out   <= '0;
            data_valid <= 1'b0;
        end else begin
            data_valid <= comb_stb;
            if (comb_stb) data_out <= $signed(total[DATA_W-1:0]);
        end
    end
endmodule

// File: rtl/ocd_trip.sv
// Window comparator with start-up blanking and a latched trip flag.
// Readings are counted after reset, and comparisons start only once the
// mode's settle count has passed. A clear is honoured only while the latest
// compared reading was inside the window, and a new violation wins over it.
module ocd_trip
    import ocd_pkg::*;
#(
    parameter int DATA_W       = 14,
    parameter int SETTLE_SINC2 = 3,
    parameter int SETTLE_FAST  = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fast_en,
    input  logic signed [DATA_W-1:0] sample,
    input  logic                     sample_vld,
    input  logic signed [DATA_W-1:0] thr_hi,
    input  logic signed [DATA_W-1:0] thr_lo,
    input  logic                     trip_clr,
    output logic                     trip
);
    localparam int CNT_W = $clog2(SETTLE_FAST + 1);

    filt_mode_e       mode;
    logic [CNT_W-1:0] seen_q;
    logic [CNT_W-1:0] settle_need;
    logic             armed;
    logic             outside;
    logic             hit;
    logic             inside_q;

    assign mode        = filt_mode_e'(fast_en);
    assign settle_need = (mode == FILT_FAST) ? CNT_W'(SETTLE_FAST) : CNT_W'(SETTLE_SINC2);
    assign armed       = (seen_q >= settle_need);
    assign outside     = (sample > thr_hi) || (sample < thr_lo);
    assign hit         = sample_vld && armed && outside;

    // Count blanked readings after reset, saturating once armed.
    always_ff @(posedge clk) begin
        if (!rst_n)                   seen_q <= '0;
        else if (sample_vld && !armed) seen_q <= seen_q + 1'b1;
    end

    // Remember whether the latest compared reading sat inside the window.
    always_ff @(posedge clk) begin
        if (!rst_n)                   inside_q <= 1'b1;
        else if (sample_vld && armed) inside_q <= !outside;
    end

    // Sticky trip flag: set by a violation, cleared by an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n)                    trip <= 1'b0;
        else if (hit)                  trip <= 1'b1;
        else if (trip_clr && inside_q) trip <= 1'b0;
    end
endmodule

// File: rtl/ocd_detector.sv
// Fast overcurrent sinc detector top level.
// Chains the decimator, the echo/offset stage and the window comparator.
// Assumes osr_sel and fast_en change only while reset is applied.
module ocd_detector
    import ocd_pkg::*;
#(
    parameter  int OSR_LOG2_MIN = OCD_OSR_LOG2_MIN,
    parameter  int OSR_LOG2_MAX = OCD_OSR_LOG2_MAX,
    localparam int SEL_W        = $clog2(OSR_LOG2_MAX - OSR_LOG2_MIN + 1),
    localparam int DATA_W       = 2 * OSR_LOG2_MAX + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bit_in,
    input  logic [SEL_W-1:0]         osr_sel,
    input  logic                     fast_en,
    input  logic signed [DATA_W-1:0] thr_hi,
    input  logic signed [DATA_W-1:0] thr_lo,
    input  logic                     trip_clr,
    output logic signed [DATA_W-1:0] data_out,
    output logic                     data_valid,
    output logic                     trip
);
    logic [DATA_W-1:0] comb_out;
    logic              comb_stb;

    ocd_cic2 #(
        .OSR_LOG2_MIN(OSR_LOG2_MIN),
        .OSR_LOG2_MAX(OSR_LOG2_MAX),
        .SEL_W       (SEL_W),
        .ACC_W       (DATA_W)
    ) u_cic2 (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_in  (bit_in),
        .osr_sel (osr_sel),
        .comb_out(comb_out),
        .comb_stb(comb_stb)
    );

    ocd_fast_term #(
        .OSR_LOG2_MIN(OSR_LOG2_MIN),
        .SEL_W       (SEL_W),
        .DATA_W      (DATA_W),
        .LAG         (OCD_LAG)
    ) u_fast_term (
        .clk       (clk),
        .rst_n     (rst_n),
        .fast_en   (fast_en),
        .osr_sel   (osr_sel),
        .comb_in   (comb_out),
        .comb_stb  (comb_stb),
        .data_out  (data_out),
        .data_valid(data_valid)
    );

    ocd_trip #(
        .DATA_W      (DATA_W),
        .SETTLE_SINC2(OCD_SETTLE_SINC2),
        .SETTLE_FAST (OCD_SETTLE_FAST)
    ) u_trip (
        .clk       (clk),
        .rst_n     (rst_n),
        .fast_en   (fast_en),
        .sample    (data_out),
        .sample_vld(data_valid),
        .thr_hi    (thr_hi),
        .thr_lo    (thr_lo),
        .trip_clr  (trip_clr),
        .trip      (trip)
    );
endmodule

// File: rtl/ocd_detector_chk.sv
// Property checker for ocd_detector, attached with the bind below.
// Tracks the spacing of reading strobes with its own counter and checks the
// reading range and the trip flag's set, hold and clear behaviour.
module ocd_detector_chk #(
    parameter int OSR_LOG2_MIN = 3,
    parameter int OSR_LOG2_MAX = 6,
    parameter int SEL_W        = 2,
    parameter int DATA_W       = 14
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [SEL_W-1:0]         osr_sel,
    input logic                     fast_en,
    input logic                     trip_clr,
    input logic signed [DATA_W-1:0] data_out,
    input logic                     data_valid,
    input logic                     trip
);
    localparam int GAP_W = OSR_LOG2_MAX + 1;

    logic [GAP_W-1:0] gap_q;
    logic             seen_q;
    int               osr_m1;
    int               half;

    assign osr_m1 = (1 << (OSR_LOG2_MIN + int'(osr_sel))) - 1;
    assign half   = (1 << (2 * (OSR_LOG2_MIN + int'(osr_sel)))) >> (fast_en ? 0 : 1);

    // Clocks elapsed since the last reading strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (data_valid) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else begin
            gap_q  <= gap_q + 1'b1;
        end
    end

    // R2
    valid_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && seen_q) |-> (int'(gap_q) == osr_m1));

    // R2
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |=> !data_valid);

    // R5
    data_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> (data_out <= half && data_out >= -half));

    // R7
    trip_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trip) |-> $past(data_valid));

    // R8
    trip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trip && !trip_clr) |=> trip);

    // R9
    trip_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(trip) |-> ($past(trip_clr) || !$past(rst_n)));
endmodule

bind ocd_detector ocd_detector_chk #(
    .OSR_LOG2_MIN(OSR_LOG2_MIN),
    .OSR_LOG2_MAX(OSR_LOG2_MAX),
    .SEL_W       (SEL_W),
    .DATA_W      (DATA_W)
) u_ocd_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .osr_sel   (osr_sel),
    .fast_en   (fast_en),
    .trip_clr  (trip_clr),
    .data_out  (data_out),
    .data_valid(data_valid),
    .trip      (trip)
);

// File: tb/ocd_detector_bench.sv
`timescale 1ns/1ps
module ocd_detector_bench;
    import ocd_pkg::*;
    localparam int DW = OCD_DATA_W;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 bit_in = 1'b0;
    logic [1:0]           osr_sel = 2'd0;
    logic                 fast_en = 1'b0;
    logic signed [DW-1:0] thr_hi = '0;
    logic signed [DW-1:0] thr_lo = '0;
    logic                 trip_clr = 1'b0;
    logic signed [DW-1:0] data_out;
    logic                 data_valid;
    logic                 trip;

    int         checks = 0;
    int         fails = 0;
    logic [3:0] pat = 4'b0101;
    logic [1:0] ph = 2'd0;

    // {fast_en, osr_sel[1:0], repeating 4-bit pattern}
    localparam logic [6:0] VEC [9] = '{
        {1'b0, 2'd0, 4'b1111}, {1'b0, 2'd1, 4'b0000}, {1'b0, 2'd2, 4'b0101},
        {1'b0, 2'd3, 4'b0111}, {1'b1, 2'd0, 4'b0001}, {1'b1, 2'd1, 4'b1111},
        {1'b1, 2'd3, 4'b1111}, {1'b1, 2'd3, 4'b0000}, {1'b1, 2'd2, 4'b1011}
    };

    always #2.5 clk = ~clk;

    ocd_detector u_ocd_detector (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .osr_sel(osr_sel),
        .fast_en(fast_en), .thr_hi(thr_hi), .thr_lo(thr_lo), .trip_clr(trip_clr),
        .data_out(data_out), .data_valid(data_valid), .trip(trip)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Advance to the next falling edge, then drive the next stream bit.
    task automatic tick();
        @(negedge clk);
        bit_in = pat[ph];
        ph = ph + 2'd1;
    endtask

    function automatic int osr_of(input logic [1:0] s);
        return 8 << s;
    endfunction

    task automatic do_reset(input logic f, input logic [1:0] s);
        rst_n = 1'b0;
        fast_en = f;
        osr_sel = s;
        repeat (3) tick();
        rst_n = 1'b1;
    endtask

    task automatic run_periods(input int n);
        repeat (n * osr_of(osr_sel)) tick();
    endtask

    task automatic wait_valid();
        int guard = 0;
        do begin
            tick();
            guard++;
        end while (!data_valid && guard < 1000);
    endtask

    task automatic pulse_clr();
        tick();
        trip_clr = 1'b1;
        tick();
        trip_clr = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin : main
        int exp;
        int n;
        int first;
        int tripped;

        // R1: outputs held at zero during reset
        do_reset(1'b0, 2'd0);
        rst_n = 1'b0;
        tick();
        check("R1 data_out", int'(data_out), 0);
        check("R1 data_valid", int'(data_valid), 0);
        check("R1 trip", int'(trip), 0);

        // R2, R3, R4: settled readings across the vector table
        foreach (VEC[i]) begin
            pat    = VEC[i][3:0];
            thr_hi = {1'b0, {(DW-1){1'b1}}};
            thr_lo = {1'b1, {(DW-1){1'b0}}};
            do_reset(VEC[i][6], VEC[i][5:4]);
            run_periods(8);
            wait_valid();
            exp = (VEC[i][6] ? 2 : 1) * osr_of(VEC[i][5:4]) * osr_of(VEC[i][5:4])
                  * ($countones(VEC[i][3:0]) - 2) / 4;
            check(VEC[i][6] ? "R4 settled reading" : "R3 settled reading", int'(data_out), exp);
            n = 0;
            do begin
                tick();
                n++;
            end while (!data_valid && n < 1000);
            check("R2 strobe period", n, osr_of(VEC[i][5:4]));
            check("R7 wide window no trip", int'(trip), 0);
        end

        // R6: start-up readings are blanked in both modes
        for (int f = 0; f < 2; f++) begin
            pat = 4'b0101;
            thr_hi = 1;
            thr_lo = -1;
            do_reset(f[0], 2'd0);
            wait_valid();
            first = int'(data_out);
            check("R6 first reading below window", int'(first < -1), 1);
            tripped = 0;
            repeat (12 * 8) begin
                tick();
                if (trip) tripped = 1;
            end
            check("R6 no trip during blanking", tripped, 0);
            check("R6 settled mid-scale", int'(data_out), 0);
        end

        // R10, R9, R8: fast-mode step, clear attempts, stickiness
        pat = 4'b0101;
        thr_hi = 64;
        thr_lo = -64;
        do_reset(1'b1, 2'd1);
        run_periods(8);
        check("R10 no trip before step", int'(trip), 0);
        pat = 4'b0111;
        n = 0;
        while (!trip && n < 400) begin
            tick();
            n++;
        end
        check("R10 fast trip latency", int'(n <= 80), 1);
        run_periods(4);
        pulse_clr();
        check("R9 clear ignored while outside", int'(trip), 1);
        pat = 4'b0101;
        run_periods(8);
        check("R8 trip held after return", int'(trip), 1);
        pulse_clr();
        check("R9 clear accepted inside", int'(trip), 0);

        // R10: second-order mode step
        pat = 4'b0101;
        thr_hi = 32;
        thr_lo = -32;
        do_reset(1'b0, 2'd1);
        run_periods(8);
        pat = 4'b0111;
        n = 0;
        while (!trip && n < 400) begin
            tick();
            n++;
        end
        check("R10 sinc2 trip latency", int'(n <= 80), 1);

        // R7: equality with the upper threshold does not trip
        pat = 4'b1111;
        thr_hi = 32;
        thr_lo = -32;
        do_reset(1'b0, 2'd0);
        run_periods(8);
        check("R7 reading at upper bound", int'(data_out), 32);
        check("R7 equal upper no trip", int'(trip), 0);
        thr_hi = 31;
        wait_valid();
        tick();
        check("R7 above upper trips", int'(trip), 1);

        // R7: lower threshold, fast mode
        pat = 4'b0001;
        thr_hi = 100;
        thr_lo = -32;
        do_reset(1'b1, 2'd0);
        run_periods(8);
        check("R7 equal lower no trip", int'(trip), 0);
        thr_lo = -31;
        wait_valid();
        tick();
        check("R7 below lower trips", int'(trip), 1);

        // R1: reset clears a set trip flag
        rst_n = 1'b0;
        tick();
        tick();
        check("R1 reset clears trip", int'(trip), 0);
        check("R1 reset clears valid", int'(data_valid), 0);
        check("R1 reset clears data", int'(data_out), 0);

        finish_run();
    end
endmodule